// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the 16-bit status word of a small processor. When the execution unit finishes an 8-bit or 16-bit addition or subtraction, it presents both operands, the result, the kind of operation and the operand size to this block, together with an update enable. On the next clock edge the block works out the carry, parity, half-carry, zero, sign and overflow conditions and stores them at fixed bit positions in the status word.

The word also holds three control bits: single-step trap, interrupt enable and string direction. Only explicit set and clear strobes change them. The direction bit is decoded into a signed step value, plus or minus one for byte strings and plus or minus two for word strings, which the string unit adds to its source and destination pointers.

Top module: `psw_unit`

## Requirements
- R1: After reset, every bit of `psw` is 0. Interrupts are therefore disabled and the step is an increment.
- R2: When `upd_en` is low, the condition flags (bits 0, 2, 4, 6, 7, 11) keep their values across clock edges.
- R3: Bit 0 (carry) holds the carry out of the top bit for an add, or the borrow into the top bit for a subtract (a < b unsigned). The top bit is bit 7 when `is_word`=0 and bit 15 when `is_word`=1.
- R4: Bit 2 (parity) is 1 when bits 7..0 of the result hold an even number of ones, for both operand sizes.
- R5: Bit 4 (half carry) is 1 when bit 4 of (a ^ b ^ result) is 1, which is a carry or borrow across the low nibble.
- R6: Bit 6 (zero) is 1 when the result is zero within the operand size. Bit 7 (sign) equals the top bit of the result.
- R7: Bit 11 (overflow) is 1 on signed overflow. For an add, this means both operands have the same sign and the result has the other sign. For a subtract, the operands have different signs and the result's sign differs from a's sign.
- R8: Bits 8 (trap), 9 (interrupt enable) and 10 (direction) change only through the set strobes `ctl_set[2:0]` and the clear strobes `ctl_clr[2:0]`. Strobe bit 0 maps to trap, bit 1 to interrupt enable and bit 2 to direction. An update with `upd_en` high leaves these bits unchanged.
- R9: When a set strobe and a clear strobe for the same bit are both high in one cycle, the clear wins.
- R10: Bits 1, 3, 5, 12, 13, 14 and 15 of `psw` always read 0.
- R11: `step` is combinational from the stored direction bit and `is_word`: +1 or +2 when the direction bit is 0, and -1 or -2 when it is 1, as a 16-bit two's-complement value.
- R12: `op_sub`=0 selects add and `op_sub`=1 selects subtract. Flags appear in `psw` one clock after the cycle in which `upd_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| upd_en | input | 1 | capture arithmetic flags this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| is_word | input | 1 | 0 = byte, 1 = word |
| opa | input | 16 | first operand |
| opb | input | 16 | second operand |
| res | input | 16 | result from the ALU |
| ctl_set | input | 3 | set strobes {dir, ie, trap} |
| ctl_clr | input | 3 | clear strobes {dir, ie, trap} |
| psw | output | 16 | status word |
| step | output | 16 | signed string pointer step |

## Verification
A wrong size select shows up as a carry, sign or zero value taken from the wrong top bit. It appears in `psw` on the cycle after the update. A corrupted control bit stays visible on the port until the next strobe. A wrong direction bit appears at once on `step`, and stays there, because `step` is combinational from the stored bit. The bench checks each update one cycle after it is applied, so a fault shows up at the first operation that depends on it.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int W      = 16;
    localparam int B_CF   = 0;
    localparam int B_PF   = 2;
    localparam int B_AF   = 4;
    localparam int B_ZF   = 6;
    localparam int B_SF   = 7;
    localparam int B_TF   = 8;
    localparam int B_IF   = 9;
    localparam int B_DF   = 10;
    localparam int B_OF   = 11;
    localparam int NCTL   = 3;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } cond_t;

    typedef struct packed {
        logic df;
        logic ie;
        logic tf;
    } ctl_t;

    typedef struct packed {
        cond_t cond;
        ctl_t  ctl;
    } psw_state_t;
endpackage

// File: rtl/psw_cond_calc.sv
module psw_cond_calc
    import psw_pkg::*;
#(
    parameter int DW = W
) (
    input  logic          op_sub,
    input  logic          is_word,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] res,
    output cond_t         cond
);
    localparam int HB = DW / 2;

    logic [DW:0]   sum_w;
    logic [HB:0]   sum_b;
    logic          a_top, b_top, r_top;
    logic          carry_w, carry_b;
    logic [DW-1:0] mixed;

    always_comb begin
        sum_w   = op_sub ? ({1'b0, opa} - {1'b0, opb}) : ({1'b0, opa} + {1'b0, opb});
        sum_b   = op_sub ? ({1'b0, opa[HB-1:0]} - {1'b0, opb[HB-1:0]})
                         : ({1'b0, opa[HB-1:0]} + {1'b0, opb[HB-1:0]});
        carry_w = sum_w[DW];
        carry_b = sum_b[HB];
        a_top   = is_word ? opa[DW-1] : opa[HB-1];
        b_top   = is_word ? opb[DW-1] : opb[HB-1];
        r_top   = is_word ? res[DW-1] : res[HB-1];
        mixed   = opa ^ opb ^ res;

        cond.cf = is_word ? carry_w : carry_b;
        cond.pf = ~(^res[7:0]);
        cond.af = mixed[4];
        cond.zf = is_word ? (res == '0) : (res[HB-1:0] == '0);
        cond.sf = r_top;
        if (op_sub) cond.of = (a_top != b_top) && (r_top != a_top);
        else        cond.of = (a_top == b_top) && (r_top != a_top);
    end
endmodule

// File: rtl/psw_step_gen.sv
module psw_step_gen
    import psw_pkg::*;
#(
    parameter int DW = W
) (
    input  logic          df,
    input  logic          is_word,
    output logic [DW-1:0] step
);
    logic [DW-1:0] mag;
    always_comb begin
        mag  = is_word ? DW'(2) : DW'(1);
        step = df ? (~mag + DW'(1)) : mag;
    end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          op_sub,
    input  logic          is_word,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  res,
    input  logic [NCTL-1:0] ctl_set,
    input  logic [NCTL-1:0] ctl_clr,
    output logic [W-1:0]  psw,
    output logic [W-1:0]  step
);
    psw_state_t st_d, st_q;
    cond_t      cond_new;
    logic [NCTL-1:0] ctl_bits;

    psw_cond_calc #(.DW(W)) u_calc (
        .op_sub (op_sub),
        .is_word(is_word),
        .opa    (opa),
        .opb    (opb),
        .res    (res),
        .cond   (cond_new)
    );

    always_comb begin
        st_d = st_q;
        if (upd_en) st_d.cond = cond_new;
        ctl_bits = (st_q.ctl | ctl_set) & ~ctl_clr;
        st_d.ctl = ctl_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        psw       = '0;
        psw[B_CF] = st_q.cond.cf;
        psw[B_PF] = st_q.cond.pf;
        psw[B_AF] = st_q.cond.af;
        psw[B_ZF] = st_q.cond.zf;
        psw[B_SF] = st_q.cond.sf;
        psw[B_OF] = st_q.cond.of;
        psw[B_TF] = st_q.ctl.tf;
        psw[B_IF] = st_q.ctl.ie;
        psw[B_DF] = st_q.ctl.df;
    end

    psw_step_gen #(.DW(W)) u_step (
        .df     (st_q.ctl.df),
        .is_word(is_word),
        .step   (step)
    );
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk
    import psw_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          upd_en,
    input logic          is_word,
    input logic [NCTL-1:0] ctl_set,
    input logic [NCTL-1:0] ctl_clr,
    input logic [W-1:0]  psw,
    input logic [W-1:0]  step
);
    localparam logic [W-1:0] COND_MASK = 16'h08D5;
    localparam logic [W-1:0] CTL_MASK  = 16'h0700;

    // R2
    hold_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> (psw & COND_MASK) == ($past(psw) & COND_MASK));
    // R8
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> (psw & CTL_MASK) == ($past(psw) & CTL_MASK));
    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clr[1] && ctl_set[1]) |=> !psw[B_IF]);
    // R10
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psw & ~(COND_MASK | CTL_MASK)) == '0);
    // R11
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step + (psw[B_DF] ? (is_word ? 16'd2 : 16'd1) : -(is_word ? 16'd2 : 16'd1))) == 0);
endmodule

bind psw_unit psw_unit_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .is_word(is_word),
    .ctl_set(ctl_set),
    .ctl_clr(ctl_clr),
    .psw    (psw),
    .step   (step)
);

// File: tb/psw_unit_test.sv
module psw_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        upd_en = 0, op_sub = 0, is_word = 0;
    logic [15:0] opa = 0, opb = 0, res = 0;
    logic [2:0]  ctl_set = 0, ctl_clr = 0;
    logic [15:0] psw, step;
    int n_chk = 0, n_bad = 0;

    typedef struct { logic [15:0] exp; logic [15:0] mask; string tag; } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    psw_unit uut (.*);

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic sub, input logic wd,
                                          input logic [15:0] a, input logic [15:0] b,
                                          output logic [15:0] r);
        logic [16:0] full;
        logic [15:0] f;
        int top;
        top = wd ? 15 : 7;
        if (!wd) begin a[15:8] = 0; b[15:8] = 0; end
        full = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        r = wd ? full[15:0] : {8'h00, full[7:0]};
        f = 0;
        f[0]  = sub ? (a < b) : (wd ? full[16] : full[8]);
        f[2]  = ~(^r[7:0]);
        f[4]  = a[4] ^ b[4] ^ r[4];
        f[6]  = (r == 0);
        f[7]  = r[top];
        f[11] = sub ? (a[top] != b[top] && r[top] != a[top])
                    : (a[top] == b[top] && r[top] != a[top]);
        return f;
    endfunction

    // driver: apply one ALU op, push expected condition bits
    task automatic do_op(input logic sub, input logic wd, input logic [15:0] a,
                         input logic [15:0] b, input string tag);
        logic [15:0] r, f;
        item_t it;
        f = model(sub, wd, a, b, r);
        @(negedge clk);
        upd_en = 1; op_sub = sub; is_word = wd; opa = a; opb = b; res = r;
        it.exp = f; it.mask = 16'h08D5; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        upd_en = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0 && !upd_en) begin
            item_t it;
            it = q.pop_front();
            check(psw & it.mask, it.exp, it.tag);
        end
    end

    task automatic ctl(input logic [2:0] s, input logic [2:0] c);
        @(negedge clk);
        ctl_set = s; ctl_clr = c;
        @(negedge clk);
        ctl_set = 0; ctl_clr = 0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(psw, 16'h0000, "R1 reset word");
        check(step, 16'h0001, "R1 reset step");
        rst_n = 1;
        do_op(0, 0, 16'h00FF, 16'h0001, "R3 R6 byte add carry zero");
        do_op(0, 0, 16'h007F, 16'h0001, "R7 byte add overflow");
        do_op(1, 0, 16'h0000, 16'h0001, "R3 byte borrow");
        do_op(1, 0, 16'h0080, 16'h0001, "R7 byte sub overflow");
        do_op(0, 0, 16'h000F, 16'h0001, "R5 half carry");
        do_op(0, 1, 16'hFFFF, 16'h0001, "R3 R12 word add carry");
        do_op(0, 1, 16'h7FFF, 16'h0001, "R7 word overflow");
        do_op(1, 1, 16'h1234, 16'h1234, "R6 word zero");
        do_op(0, 1, 16'h0100, 16'h0003, "R4 parity low byte");
        do_op(1, 1, 16'h0000, 16'h8000, "R7 word sub overflow");
        @(negedge clk);
        begin
            logic [15:0] keep;
            keep = psw;
            opa = 16'hFFFF; opb = 16'hFFFF; res = 0; op_sub = 0;
            @(negedge clk);
            check(psw, keep, "R2 no update");
        end
        ctl(3'b111, 3'b000);
        check(psw & 16'h0700, 16'h0700, "R8 set all ctl");
        is_word = 0; #1 check(step, 16'hFFFF, "R11 byte dec");
        is_word = 1; #1 check(step, 16'hFFFE, "R11 word dec");
        do_op(0, 1, 16'h0001, 16'h0001, "R12 op");
        check(psw & 16'h0700, 16'h0700, "R8 upd leaves ctl");
        ctl(3'b010, 3'b010);
        check(psw[9], 1'b0, "R9 clear wins");
        ctl(3'b000, 3'b100);
        check(step, 16'h0002, "R11 word inc");
        check(psw & 16'hF02A, 16'h0000, "R10 unused bits");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule